// File: doc/BRIEF.md
# Shared Data-Bus DMA Request Handshake

This block is the pin-level front end between a DMA controller and an external device that shares the controller's data bus. The device can ask for the bus to be released so that it can drive a request descriptor. The block answers with a one-cycle bus-available strobe. Exactly two cycles after that strobe, the block samples the data bus as a descriptor if the transfer-request pin is high in that cycle. Outside that sampling slot, the transfer-request pin is decoded in two ways. On its own it is an ordinary DMA request. Together with the release-request pin, while the block is idle, it is a direct request for channel 2.

On the channel side, a captured descriptor is handed over as a one-cycle valid pulse. This stream has no ready signal: the channel logic must take the pulse in the cycle it appears. Service acknowledges go the other way over a valid/ready stream that carries a 3-bit channel number. The block drops `svc_ready_o` only in a cycle where it is starting a bus release. The acknowledge must then stay valid, with the same channel number, until a cycle with ready high. An accepted acknowledge becomes a one-cycle reply strobe to the device in the next cycle. In that cycle the low two channel bits appear on a 2-bit output and bit 2 appears on the bus-available pin, which does double duty.

Top module: `dbus_req_hs`

## Requirements
- R1: While synchronous reset is high, and in the first cycle after it, every output other than `svc_ready_o` is low and the sequencer is idle, so a release request is accepted at once.
- R2: `rel_req_i` high with `xfer_req_i` low, while idle, makes `avail_id2_o` high for exactly one cycle, in the cycle after the request.
- R3: If `xfer_req_i` is high in the cycle two cycles after the bus-available strobe, `desc_valid_o` is high for one cycle in the following cycle and `desc_data_o` holds the value of `dbus_i` from the sampling cycle. If `xfer_req_i` is low in that slot, no descriptor is produced.
- R4: `xfer_req_i` high with `rel_req_i` low, outside the sampling slot, gives a one-cycle `dma_req_o` pulse in the next cycle.
- R5: `rel_req_i` and `xfer_req_i` high together while idle give a one-cycle `ch2_req_o` pulse in the next cycle and no bus-available strobe.
- R6: `rel_req_i` is ignored from the bus-available cycle through the sampling cycle: it produces no strobe and no channel-2 request. A request in the cycle after the sampling slot is accepted.
- R7: `xfer_req_i` in the sampling slot captures the descriptor only. It raises neither `dma_req_o` nor `ch2_req_o`, even when `rel_req_i` is also high.
- R8: An accepted acknowledge (valid and ready both high) gives `reply_stb_o` high for one cycle in the next cycle. In that cycle `chan_lo_o` equals channel bits [1:0] and `avail_id2_o` equals channel bit 2. Outside reply cycles `chan_lo_o` is zero.
- R9: `svc_ready_o` is low exactly in a cycle where a bus release is being started. A held acknowledge is replied to after that, and the bus-available strobe and the reply strobe never share a cycle.
- R10: During the release sequence, `xfer_req_i` outside the sampling slot is still an ordinary request. This holds even when `rel_req_i` is high, because that input is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rel_req_i | input | 1 | Bus-release request from the device |
| xfer_req_i | input | 1 | Transfer-request pin from the device |
| dbus_i | input | DW | Shared data bus, sampled for descriptors |
| svc_valid_i | input | 1 | Service acknowledge valid from channel logic |
| svc_chan_i | input | 3 | Channel number of the acknowledge |
| svc_ready_o | output | 1 | Acknowledge accepted this cycle when valid |
| avail_id2_o | output | 1 | Bus-available strobe, or channel bit 2 during a reply |
| reply_stb_o | output | 1 | Reply strobe to the device |
| chan_lo_o | output | 2 | Channel bits [1:0] during a reply |
| dma_req_o | output | 1 | Ordinary DMA request pulse |
| ch2_req_o | output | 1 | Direct channel-2 request pulse |
| desc_valid_o | output | 1 | Descriptor valid pulse |
| desc_data_o | output | DW | Captured descriptor |

## Verification
The bench builds the block with a 16-bit bus and the default two-cycle sampling gap. Two 16-bit descriptor patterns, each the bitwise inverse of the other, are enough to show that every bit position is captured, and the gap keeps the whole release window within a few vectors. With that window this short, the walk can place a release request in each of the ignored cycles and the first accepted one, and place a transfer request both in and out of the slot. It can also hold an acknowledge across a ready-low cycle and then see its reply land inside the release window.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int CHAN_W = 3;
  typedef logic [CHAN_W-1:0] chan_t;
endpackage

// File: rtl/hs_req_decode.sv
module hs_req_decode (
  input  logic clk,
  input  logic rst,
  input  logic rel_req_i,
  input  logic xfer_req_i,
  input  logic busy_i,
  input  logic sample_now_i,
  output logic launch_o,
  output logic dma_req_o,
  output logic ch2_req_o
);
  logic direct_c, ordinary_c;
  logic dma_req_q, ch2_req_q;

  // rel_req_i only counts while the sequencer is idle
  assign launch_o   = !busy_i && rel_req_i && !xfer_req_i;
  assign direct_c   = !busy_i && rel_req_i && xfer_req_i;
  assign ordinary_c = xfer_req_i && !direct_c && !sample_now_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_req_q <= 1'b0;
      ch2_req_q <= 1'b0;
    end else begin
      dma_req_q <= ordinary_c;
      ch2_req_q <= direct_c;
    end
  end

  assign dma_req_o = dma_req_q;
  assign ch2_req_o = ch2_req_q;

  // a slot capture never doubles as a request
  assert_slot_not_request_R7: assert property (@(posedge clk) disable iff (rst)
    (sample_now_i && xfer_req_i) |=> (!dma_req_q && !ch2_req_q));
  assert_direct_only_idle_R5: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> !ch2_req_q);
endmodule

// File: rtl/hs_release_seq.sv
module hs_release_seq #(
  parameter int DW  = 32,
  parameter int GAP = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch_i,
  input  logic          xfer_req_i,
  input  logic [DW-1:0] dbus_i,
  output logic          busy_o,
  output logic          sample_now_o,
  output logic          avail_o,
  output logic          desc_valid_o,
  output logic [DW-1:0] desc_data_o
);
  localparam int CW = $clog2(GAP + 1);

  logic          busy_q, avail_q, dvalid_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] desc_q;

  assign sample_now_o = busy_q && (cnt_q == CW'(GAP));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      avail_q  <= 1'b0;
      dvalid_q <= 1'b0;
      desc_q   <= '0;
    end else begin
      avail_q  <= launch_i;
      dvalid_q <= sample_now_o && xfer_req_i;
      if (sample_now_o && xfer_req_i) desc_q <= dbus_i;
      if (launch_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (sample_now_o) busy_q <= 1'b0;
        else              cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o       = busy_q;
  assign avail_o      = avail_q;
  assign desc_valid_o = dvalid_q;
  assign desc_data_o  = desc_q;

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
    avail_q |=> !avail_q);
  assert_busy_blocks_launch_R6: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> !avail_q);
  assert_desc_after_slot_R3: assert property (@(posedge clk) disable iff (rst)
    dvalid_q |-> $past(busy_q));
  assert_desc_single_R3: assert property (@(posedge clk) disable iff (rst)
    dvalid_q |=> !dvalid_q);
endmodule

// File: rtl/hs_reply_gen.sv
module hs_reply_gen
  import hs_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  launch_i,
  input  logic  svc_valid_i,
  input  chan_t svc_chan_i,
  output logic  svc_ready_o,
  output logic  reply_o,
  output chan_t chan_o
);
  logic  reply_q, accept_c;
  chan_t chan_q;

  // the bus-available strobe owns the shared pin in the next cycle
  assign svc_ready_o = !launch_i;
  assign accept_c    = svc_valid_i && svc_ready_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      reply_q <= 1'b0;
      chan_q  <= '0;
    end else begin
      reply_q <= accept_c;
      chan_q  <= accept_c ? svc_chan_i : '0;
    end
  end

  assign reply_o = reply_q;
  assign chan_o  = chan_q;

  assert_reply_from_ack_R8: assert property (@(posedge clk) disable iff (rst)
    reply_q |-> $past(svc_valid_i));
  assert_chan_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !reply_q |-> (chan_q == '0));
endmodule

// File: rtl/dbus_req_hs.sv
module dbus_req_hs
  import hs_pkg::*;
#(
  parameter int DW  = 32,
  parameter int GAP = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rel_req_i,
  input  logic          xfer_req_i,
  input  logic [DW-1:0] dbus_i,
  input  logic          svc_valid_i,
  input  logic [2:0]    svc_chan_i,
  output logic          svc_ready_o,
  output logic          avail_id2_o,
  output logic          reply_stb_o,
  output logic [1:0]    chan_lo_o,
  output logic          dma_req_o,
  output logic          ch2_req_o,
  output logic          desc_valid_o,
  output logic [DW-1:0] desc_data_o
);
  logic  launch, busy, sample_now, avail, reply;
  chan_t chan;

  hs_req_decode u_dec (
    .clk          (clk),
    .rst          (rst),
    .rel_req_i    (rel_req_i),
    .xfer_req_i   (xfer_req_i),
    .busy_i       (busy),
    .sample_now_i (sample_now),
    .launch_o     (launch),
    .dma_req_o    (dma_req_o),
    .ch2_req_o    (ch2_req_o)
  );

  hs_release_seq #(.DW(DW), .GAP(GAP)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .launch_i     (launch),
    .xfer_req_i   (xfer_req_i),
    .dbus_i       (dbus_i),
    .busy_o       (busy),
    .sample_now_o (sample_now),
    .avail_o      (avail),
    .desc_valid_o (desc_valid_o),
    .desc_data_o  (desc_data_o)
  );

  hs_reply_gen u_rep (
    .clk         (clk),
    .rst         (rst),
    .launch_i    (launch),
    .svc_valid_i (svc_valid_i),
    .svc_chan_i  (chan_t'(svc_chan_i)),
    .svc_ready_o (svc_ready_o),
    .reply_o     (reply),
    .chan_o      (chan)
  );

  // shared pin: strobe or channel bit 2, never both
  assign avail_id2_o = avail | (reply & chan[2]);
  assign reply_stb_o = reply;
  assign chan_lo_o   = chan[1:0];

  assert_pin_no_overlap_R9: assert property (@(posedge clk) disable iff (rst)
    !(avail && reply));
  assert_ready_tracks_launch_R9: assert property (@(posedge clk) disable iff (rst)
    (rel_req_i && !xfer_req_i && !busy) |-> !svc_ready_o);
endmodule

// File: tb/dbus_req_hs_tb.sv
module dbus_req_hs_tb;
  localparam int DW = 16;
  localparam int NV = 21;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rel_req_i = 1'b0, xfer_req_i = 1'b0, svc_valid_i = 1'b0;
  logic [DW-1:0] dbus_i = '0;
  logic [2:0]    svc_chan_i = '0;
  logic          svc_ready_o, avail_id2_o, reply_stb_o, dma_req_o, ch2_req_o, desc_valid_o;
  logic [1:0]    chan_lo_o;
  logic [DW-1:0] desc_data_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dbus_req_hs #(.DW(DW), .GAP(2)) u_dut (
    .clk(clk), .rst(rst), .rel_req_i(rel_req_i), .xfer_req_i(xfer_req_i),
    .dbus_i(dbus_i), .svc_valid_i(svc_valid_i), .svc_chan_i(svc_chan_i),
    .svc_ready_o(svc_ready_o), .avail_id2_o(avail_id2_o), .reply_stb_o(reply_stb_o),
    .chan_lo_o(chan_lo_o), .dma_req_o(dma_req_o), .ch2_req_o(ch2_req_o),
    .desc_valid_o(desc_valid_o), .desc_data_o(desc_data_o)
  );

  // inputs: rel xfer sv ch[2:0] dbus | expected: av rp lo[1:0] dq c2 dv rdy desc
  function automatic logic [45:0] mk(logic rl, logic xf, logic sv, logic [2:0] ch,
      logic [15:0] db, logic av, logic rp, logic [1:0] lo, logic dq, logic c2,
      logic dv, logic rdy, logic [15:0] ds);
    return {rl, xf, sv, ch, db, av, rp, lo, dq, c2, dv, rdy, ds};
  endfunction

  localparam logic [45:0] VEC [NV] = '{
    mk(0,0,0,3'd0,16'h0000, 0,0,2'd0,0,0,0,1,16'h0000), // 0 idle
    mk(0,1,0,3'd0,16'h0000, 0,0,2'd0,1,0,0,1,16'h0000), // 1 ordinary R4
    mk(0,0,0,3'd0,16'h0000, 0,0,2'd0,0,0,0,1,16'h0000), // 2
    mk(1,1,0,3'd0,16'h0000, 0,0,2'd0,0,1,0,1,16'h0000), // 3 direct ch2 R5
    mk(1,0,0,3'd0,16'h0000, 1,0,2'd0,0,0,0,0,16'h0000), // 4 launch R2
    mk(1,0,0,3'd0,16'h0000, 0,0,2'd0,0,0,0,1,16'h0000), // 5 ignored R6
    mk(0,0,0,3'd0,16'h0000, 0,0,2'd0,0,0,0,1,16'h0000), // 6
    mk(0,1,0,3'd0,16'hA5C3, 0,0,2'd0,0,0,1,1,16'hA5C3), // 7 slot R3 R7
    mk(0,0,0,3'd0,16'h0000, 0,0,2'd0,0,0,0,1,16'h0000), // 8
    mk(0,0,1,3'd6,16'h0000, 1,1,2'd2,0,0,0,1,16'h0000), // 9 reply R8
    mk(0,0,1,3'd1,16'h0000, 0,1,2'd1,0,0,0,1,16'h0000), // 10 reply R8
    mk(0,0,0,3'd0,16'h0000, 0,0,2'd0,0,0,0,1,16'h0000), // 11
    mk(1,0,1,3'd5,16'h0000, 1,0,2'd0,0,0,0,0,16'h0000), // 12 launch stalls ack R9
    mk(0,0,1,3'd5,16'h0000, 1,1,2'd1,0,0,0,1,16'h0000), // 13 held ack replied R9
    mk(1,1,0,3'd0,16'h0000, 0,0,2'd0,1,0,0,1,16'h0000), // 14 busy ordinary R10
    mk(0,0,0,3'd0,16'h1111, 0,0,2'd0,0,0,0,1,16'h0000), // 15 empty slot R3
    mk(1,0,0,3'd0,16'h0000, 1,0,2'd0,0,0,0,0,16'h0000), // 16 relaunch R6
    mk(0,0,0,3'd0,16'h0000, 0,0,2'd0,0,0,0,1,16'h0000), // 17
    mk(0,0,0,3'd0,16'h0000, 0,0,2'd0,0,0,0,1,16'h0000), // 18
    mk(1,1,0,3'd0,16'h5A3C, 0,0,2'd0,0,0,1,1,16'h5A3C), // 19 slot with both R7
    mk(0,0,0,3'd0,16'h0000, 0,0,2'd0,0,0,0,1,16'h0000)  // 20
  };

  function automatic string vtag(int i);
    case (i)
      1: return "R4";  3: return "R5";  4: return "R2";  5: return "R6";
      7: return "R3";  9, 10: return "R8"; 12, 13: return "R9";
      14: return "R10"; 15: return "R3"; 16: return "R6"; 19: return "R7";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [7:0] outs();
    return {avail_id2_o, reply_stb_o, chan_lo_o, dma_req_o, ch2_req_o, desc_valid_o, 1'b0};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic zero_inputs();
    rel_req_i = 0; xfer_req_i = 0; svc_valid_i = 0; svc_chan_i = '0; dbus_i = '0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1;
    chk("R1 outputs in reset", {24'd0, outs()}, 32'd0);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1 outputs after reset", {24'd0, outs()}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [45:0] v;
      v = VEC[i];
      @(negedge clk);
      rel_req_i = v[45]; xfer_req_i = v[44]; svc_valid_i = v[43];
      svc_chan_i = v[42:40]; dbus_i = v[39:24];
      #1;
      chk({vtag(i), " ready R9"}, {31'd0, svc_ready_o}, {31'd0, v[16]});
      @(posedge clk); #1;
      chk({vtag(i), " outputs"}, {24'd0, outs()}, {24'd0, v[23:17], 1'b0});
      if (v[17]) chk({vtag(i), " descriptor R3"}, {16'd0, desc_data_o}, {16'd0, v[15:0]});
    end

    // R1: reset in the middle of a release with a pending reply
    @(negedge clk); rel_req_i = 1; svc_valid_i = 0;
    @(negedge clk); zero_inputs(); svc_valid_i = 1; svc_chan_i = 3'd7;
    @(negedge clk); zero_inputs(); rst = 1;
    @(posedge clk); #1;
    chk("R1 mid-run reset", {24'd0, outs()}, 32'd0);
    @(negedge clk); rst = 0; rel_req_i = 1;
    @(posedge clk); #1;
    chk("R1 idle after reset accepts release", {31'd0, avail_id2_o}, 32'd1);
    @(negedge clk); zero_inputs();
    @(posedge clk); #1;
    chk("R2 strobe one cycle", {31'd0, avail_id2_o}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule